// File: doc/BRIEF.md
# Effective Address and Branch Target Generator

This block forms the three addresses that a 64-bit integer pipeline derives from an instruction in its execute stage. From a base register value and the 16-bit immediate held in the low half of the instruction word, it computes the load/store effective address. From the program counter, it computes the target of a PC-relative branch and the return address stored by branch-and-link forms. Whether a branch is taken, translation, exceptions and the memory access itself are handled elsewhere.

A mode input selects how each sum is formed. In wide mode, the full 64-bit sum is used and wraps modulo 2^64. In narrow mode, each sum is cut to its low 32 bits and bit 31 is copied into bits 63:32. Every narrow-mode result is therefore a canonical sign-extended address. Overflow is never flagged.

The parameter `OUT_REG` selects the output stage. With `OUT_REG=1` (the default), one register stage sits at the output and a valid bit travels with the results. With `OUT_REG=0`, the outputs follow the inputs combinationally. All widths and step constants are parameters.

Top module: `agu_addr_gen`

## Requirements
- R1: In wide mode, `ea_o` equals `base_i` plus the sign-extended `insn_i[15:0]`, taken modulo 2^64.
- R2: In narrow mode, each output is the low 32 bits of its sum with bit 31 copied into bits 63:32. Bits 63:32 of `base_i` and `pc_i` have no effect on any output in narrow mode.
- R3: `br_tgt_o` equals (`pc_i` + 4) plus the sign-extended `insn_i[15:0]` shifted left by 2. A negative offset stays negative after the shift.
- R4: `link_o` equals `pc_i` + 8, formed under the same mode rule as the other outputs.
- R5: In narrow mode, a sum that crosses 0x7FFFFFFF to 0x80000000 gives 0xFFFFFFFF80000000, and 0x80000000 - 1 gives 0x000000007FFFFFFF. In wide mode, 0x7FFFFFFF + 1 gives 0x0000000080000000. No overflow indication exists.
- R6: `insn_i[31:16]` has no effect on any output.
- R7: With `OUT_REG=1`, the results for an input with `in_valid` high appear one cycle later together with `out_valid` high. Back-to-back inputs give back-to-back results. When `in_valid` is low, `out_valid` drops in the next cycle and the result outputs keep their last values.
- R8: While `rst_n` is low, `out_valid` and all result outputs are zero.
- R9: In wide mode, a sum past 0xFFFFFFFFFFFFFFFF wraps to the low 64 bits without any indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs on this cycle carry an instruction |
| base_i | input | 64 | Base register value |
| insn_i | input | 32 | Instruction word; only bits 15:0 are used |
| pc_i | input | 64 | Address of the instruction |
| wide_mode_i | input | 1 | 1 = full 64-bit sums, 0 = 32-bit sums sign-extended |
| out_valid | output | 1 | Results below are for an accepted instruction |
| ea_o | output | 64 | Load/store effective address |
| br_tgt_o | output | 64 | PC-relative branch target |
| link_o | output | 64 | Return address for branch-and-link |

## Verification
The properties assume that `wide_mode_i` and the data inputs are sampled with `in_valid` in the same cycle. They also assume that the low 32 bits of every result can be predicted from the low 32 bits of the operands alone, whatever the mode. The stimulus changes inputs only on the falling edge and holds `in_valid` low throughout reset. It uses operands chosen to land on the 32-bit sign boundary, on the 64-bit wrap and on negative immediates. It also pairs inputs that differ only in ignored bits, so that the outputs can be compared directly.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic {
      MODE_NARROW = 1'b0,
      MODE_WIDE   = 1'b1
   } agu_mode_e;

   localparam int unsigned AGU_XLEN_DEF   = 64;
   localparam int unsigned AGU_NARROW_DEF = 32;
   localparam int unsigned AGU_IMM_DEF    = 16;
   localparam int unsigned AGU_INSN_DEF   = 32;
endpackage

// File: rtl/agu_imm_ext.sv
module agu_imm_ext #(
   parameter int unsigned IN_W  = 16,
   parameter int unsigned OUT_W = 64,
   parameter int unsigned SHIFT = 0
) (
   input  logic [IN_W-1:0]  imm_i,
   output logic [OUT_W-1:0] ext_o
);
   localparam int unsigned PAD_W = OUT_W - IN_W;

   logic [OUT_W-1:0] sext;

   assign sext = {{PAD_W{imm_i[IN_W-1]}}, imm_i};

   generate
      if (SHIFT == 0) begin : g_plain
         assign ext_o = sext;
      end else begin : g_shifted
         assign ext_o = {sext[OUT_W-1-SHIFT:0], {SHIFT{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/agu_mode_adder.sv
module agu_mode_adder #(
   parameter int unsigned XLEN   = 64,
   parameter int unsigned NARROW = 32
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic            wide_i,
   output logic [XLEN-1:0] sum_o
);
   import agu_pkg::*;

   localparam int unsigned HI_W = XLEN - NARROW;

   logic [XLEN-1:0]   full_sum;
   logic [NARROW-1:0] low_sum;
   agu_mode_e         mode;

   assign full_sum = a_i + b_i;
   assign low_sum  = a_i[NARROW-1:0] + b_i[NARROW-1:0];
   assign mode     = agu_mode_e'(wide_i);

   always_comb begin
      unique case (mode)
         MODE_WIDE:   sum_o = full_sum;
         MODE_NARROW: sum_o = {{HI_W{low_sum[NARROW-1]}}, low_sum};
         default:     sum_o = full_sum;
      endcase
   end
endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
   parameter int unsigned W       = 192,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         valid_i,
   input  logic [W-1:0] data_i,
   output logic         valid_o,
   output logic [W-1:0] data_o
);
   generate
      if (OUT_REG) begin : g_reg
         logic         vld_q;
         logic [W-1:0] dat_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               dat_q <= '0;
            end else begin
               vld_q <= valid_i;
               if (valid_i) dat_q <= data_i;
            end
         end

         assign valid_o = vld_q;
         assign data_o  = dat_q;
      end else begin : g_comb
         logic unused_stage;
         assign unused_stage = clk ^ rst_n;
         assign valid_o = valid_i;
         assign data_o  = data_i;
      end
   endgenerate
endmodule

// File: rtl/agu_addr_gen.sv
module agu_addr_gen #(
   parameter int unsigned XLEN      = 64,
   parameter int unsigned NARROW    = 32,
   parameter int unsigned IMM_W     = 16,
   parameter int unsigned INSN_W    = 32,
   parameter int unsigned BR_SHIFT  = 2,
   parameter int unsigned PC_STEP   = 4,
   parameter int unsigned LINK_STEP = 8,
   parameter bit          OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [XLEN-1:0]   base_i,
   input  logic [INSN_W-1:0] insn_i,
   input  logic [XLEN-1:0]   pc_i,
   input  logic              wide_mode_i,
   output logic              out_valid,
   output logic [XLEN-1:0]   ea_o,
   output logic [XLEN-1:0]   br_tgt_o,
   output logic [XLEN-1:0]   link_o
);
   localparam int unsigned BUS_W = 3 * XLEN;

   generate
      if (NARROW >= XLEN) begin : g_bad_narrow
         $error("agu_addr_gen: NARROW must be below XLEN");
      end
      if (IMM_W > INSN_W) begin : g_bad_imm
         $error("agu_addr_gen: IMM_W must fit inside INSN_W");
      end
      if (IMM_W + BR_SHIFT > NARROW) begin : g_bad_shift
         $error("agu_addr_gen: shifted offset must fit in NARROW");
      end
   endgenerate

   logic [IMM_W-1:0] imm;
   logic             unused_insn;
   logic [XLEN-1:0]  mem_off;
   logic [XLEN-1:0]  br_off;
   logic [XLEN-1:0]  next_pc;
   logic [XLEN-1:0]  ea_c;
   logic [XLEN-1:0]  br_c;
   logic [XLEN-1:0]  link_c;
   logic [BUS_W-1:0] bus_c;
   logic [BUS_W-1:0] bus_q;

   assign imm         = insn_i[IMM_W-1:0];
   assign unused_insn = ^insn_i;
   assign next_pc     = pc_i + XLEN'(PC_STEP);

   agu_imm_ext #(.IN_W(IMM_W), .OUT_W(XLEN), .SHIFT(0)) u_mem_ext (
      .imm_i (imm),
      .ext_o (mem_off)
   );

   agu_imm_ext #(.IN_W(IMM_W), .OUT_W(XLEN), .SHIFT(BR_SHIFT)) u_br_ext (
      .imm_i (imm),
      .ext_o (br_off)
   );

   agu_mode_adder #(.XLEN(XLEN), .NARROW(NARROW)) u_ea_add (
      .a_i    (base_i),
      .b_i    (mem_off),
      .wide_i (wide_mode_i),
      .sum_o  (ea_c)
   );

   agu_mode_adder #(.XLEN(XLEN), .NARROW(NARROW)) u_br_add (
      .a_i    (next_pc),
      .b_i    (br_off),
      .wide_i (wide_mode_i),
      .sum_o  (br_c)
   );

   agu_mode_adder #(.XLEN(XLEN), .NARROW(NARROW)) u_link_add (
      .a_i    (pc_i),
      .b_i    (XLEN'(LINK_STEP)),
      .wide_i (wide_mode_i),
      .sum_o  (link_c)
   );

   assign bus_c = {ea_c, br_c, link_c};

   agu_out_stage #(.W(BUS_W), .OUT_REG(OUT_REG)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (in_valid),
      .data_i  (bus_c),
      .valid_o (out_valid),
      .data_o  (bus_q)
   );

   assign ea_o     = bus_q[3*XLEN-1:2*XLEN];
   assign br_tgt_o = bus_q[2*XLEN-1:XLEN];
   assign link_o   = bus_q[XLEN-1:0];
endmodule

// File: rtl/agu_addr_gen_chk.sv
module agu_addr_gen_chk #(
   parameter int unsigned XLEN      = 64,
   parameter int unsigned NARROW    = 32,
   parameter int unsigned IMM_W     = 16,
   parameter int unsigned INSN_W    = 32,
   parameter int unsigned BR_SHIFT  = 2,
   parameter int unsigned PC_STEP   = 4,
   parameter int unsigned LINK_STEP = 8,
   parameter bit          OUT_REG   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [XLEN-1:0]   base_i,
   input logic [INSN_W-1:0] insn_i,
   input logic [XLEN-1:0]   pc_i,
   input logic              wide_mode_i,
   input logic              out_valid,
   input logic [XLEN-1:0]   ea_o,
   input logic [XLEN-1:0]   br_tgt_o,
   input logic [XLEN-1:0]   link_o
);
   localparam int unsigned HI_W = XLEN - NARROW + 1;

   logic [XLEN-1:0] imm_x;
   logic [XLEN-1:0] br_x;
   logic            unused_chk;

   assign imm_x      = {{(XLEN-IMM_W){insn_i[IMM_W-1]}}, insn_i[IMM_W-1:0]};
   assign br_x       = imm_x << BR_SHIFT;
   assign unused_chk = ^insn_i;

   generate
      if (OUT_REG) begin : g_seq
         assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (out_valid == $past(in_valid)));

         assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(in_valid)) |-> ($stable(ea_o) && $stable(br_tgt_o) && $stable(link_o)));

         assert_canonical_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !$past(wide_mode_i)) |->
               ((ea_o[XLEN-1:NARROW-1] == '0 || ea_o[XLEN-1:NARROW-1] == {HI_W{1'b1}}) &&
                (br_tgt_o[XLEN-1:NARROW-1] == '0 || br_tgt_o[XLEN-1:NARROW-1] == {HI_W{1'b1}}) &&
                (link_o[XLEN-1:NARROW-1] == '0 || link_o[XLEN-1:NARROW-1] == {HI_W{1'b1}})));

         assert_ea_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (ea_o[NARROW-1:0] == $past(base_i[NARROW-1:0] + imm_x[NARROW-1:0])));

         assert_ea_wide_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(wide_mode_i)) |-> (ea_o == $past(base_i + imm_x)));

         assert_br_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (br_tgt_o[NARROW-1:0] ==
               $past(pc_i[NARROW-1:0] + NARROW'(PC_STEP) + br_x[NARROW-1:0])));

         assert_link_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (link_o[NARROW-1:0] == $past(pc_i[NARROW-1:0] + NARROW'(LINK_STEP))));
      end else begin : g_comb
         always_comb begin
            if (rst_n && in_valid) begin
               assert_ea_low_R1: assert (ea_o[NARROW-1:0] == base_i[NARROW-1:0] + imm_x[NARROW-1:0]);
               assert_link_low_R4: assert (link_o[NARROW-1:0] == pc_i[NARROW-1:0] + NARROW'(LINK_STEP));
               assert_valid_pass_R7: assert (out_valid);
            end
         end
      end
   endgenerate
endmodule

bind agu_addr_gen agu_addr_gen_chk #(
   .XLEN(XLEN), .NARROW(NARROW), .IMM_W(IMM_W), .INSN_W(INSN_W),
   .BR_SHIFT(BR_SHIFT), .PC_STEP(PC_STEP), .LINK_STEP(LINK_STEP), .OUT_REG(OUT_REG)
) u_chk (.*);

// File: tb/sim_agu_addr_gen.sv
module sim_agu_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] base_i = '0;
   logic [31:0] insn_i = '0;
   logic [63:0] pc_i = '0;
   logic        wide_mode_i = 1'b0;
   logic        out_valid;
   logic [63:0] ea_o, br_tgt_o, link_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      string       tag;
      logic [63:0] ea;
      logic [63:0] br;
      logic [63:0] lk;
   } exp_t;

   exp_t sb[$];
   logic [63:0] last_ea, last_br, last_lk;

   always #5 clk = ~clk;

   agu_addr_gen u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_i(base_i),
      .insn_i(insn_i), .pc_i(pc_i), .wide_mode_i(wide_mode_i),
      .out_valid(out_valid), .ea_o(ea_o), .br_tgt_o(br_tgt_o), .link_o(link_o)
   );

   function automatic logic [63:0] fold(input logic [63:0] s, input bit w);
      return w ? s : {{32{s[31]}}, s[31:0]};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input string tag, input bit w, input logic [63:0] b,
                        input logic [31:0] ins, input logic [63:0] pc);
      exp_t e;
      logic [63:0] off;
      @(negedge clk);
      in_valid    = 1'b1;
      wide_mode_i = w;
      base_i      = b;
      insn_i      = ins;
      pc_i        = pc;
      off   = {{48{ins[15]}}, ins[15:0]};
      e.tag = tag;
      e.ea  = fold(b + off, w);
      e.br  = fold(pc + 64'd4 + (off << 2), w);
      e.lk  = fold(pc + 64'd8, w);
      sb.push_back(e);
   endtask

   // monitor: pops one expected item per valid result
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R7 unexpected out_valid", 64'd1, 64'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(ea_o == e.ea, {e.tag, " ea"}, ea_o, e.ea);
               check(br_tgt_o == e.br, {e.tag, " br"}, br_tgt_o, e.br);
               check(link_o == e.lk, {e.tag, " link"}, link_o, e.lk);
               last_ea = e.ea; last_br = e.br; last_lk = e.lk;
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      repeat (3) begin
         @(negedge clk);
         check(out_valid == 1'b0, "R8 out_valid in reset", 64'(out_valid), 64'd0);
         check((ea_o | br_tgt_o | link_o) == 64'd0, "R8 outputs in reset", ea_o | br_tgt_o | link_o, 64'd0);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // back-to-back stream (R7)
      drive("R1 R3 R4 wide positive", 1'b1, 64'h1000, 32'h0000_0010, 64'h0040_0000);
      drive("R1 R3 wide negative imm", 1'b1, 64'h1000, 32'h0000_FFF0, 64'h0040_0100);
      drive("R5 narrow cross up", 1'b0, 64'h7FFF_FFFF, 32'h0000_0001, 64'h0000_0000_0000_2000);
      drive("R5 wide cross up", 1'b1, 64'h7FFF_FFFF, 32'h0000_0001, 64'h0000_0000_0000_2000);
      drive("R2 narrow ignores upper base", 1'b0, 64'hDEAD_BEEF_0000_1000, 32'h0000_0004, 64'hCAFE_0000_0000_3000);
      drive("R4 R5 narrow link across sign", 1'b0, 64'h0, 32'h0, 64'h0000_0000_7FFF_FFF8);
      drive("R6 upper insn bits zero", 1'b0, 64'h0000_0000_1234_0000, 32'h0000_8000, 64'h0000_0000_0010_0000);
      drive("R6 upper insn bits set", 1'b0, 64'h0000_0000_1234_0000, 32'hFFFF_8000, 64'h0000_0000_0010_0000);
      drive("R9 wide wrap 64", 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0001, 64'hFFFF_FFFF_FFFF_FFF8);
      drive("R5 narrow cross down", 1'b0, 64'h0000_0000_8000_0000, 32'h0000_FFFF, 64'h0000_0000_8000_0000);
      drive("R3 narrow branch back", 1'b0, 64'h0, 32'h0000_8000, 64'h0000_0000_0000_0100);

      @(negedge clk);
      in_valid = 1'b0;
      base_i   = 64'h5555_5555_5555_5555;
      pc_i     = 64'hAAAA_AAAA_AAAA_AAAA;
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0, "R7 out_valid drops when idle", 64'(out_valid), 64'd0);
      check(ea_o == last_ea, "R7 ea holds when idle", ea_o, last_ea);
      check(link_o == last_lk, "R7 link holds when idle", link_o, last_lk);
      check(sb.size() == 0, "R7 all results delivered", 64'(sb.size()), 64'd0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule